// File: doc/BRIEF.md
# Compressed Instruction Expander

This block sits between instruction fetch and decode in an integer core. It receives a 32-bit fetched word. If the two lowest bits are 11, the word is already a full-width instruction and goes out unchanged. Any other value in those bits marks the low halfword as a compressed instruction, and the block rebuilds the equivalent full-width base-ISA instruction. Decode and execute then only ever see full-width encodings.

The block is purely combinational. Three quadrant decoders run in parallel and the top selects one of them. Each decoder gathers the scattered immediate bits of the compressed form back into the immediate layout of the target format. It maps 3-bit register fields onto x8..x15 and tells apart opcodes that share an encoding by the register numbers they carry. When an encoding is reserved, names a floating-point form, or breaks a non-zero rule, the block raises the illegal flag and emits a harmless `addi x0, x0, 0` (0x00000013).

The parameter `WIDE_CORE` selects the 64-bit decode (1, the default) or the 32-bit decode (0). In 64-bit mode the shared slots hold doubleword and word-arithmetic forms. In 32-bit mode the same slots hold jump-and-link or are rejected.

Top module: `cexp_top`

## Requirements
- R1: A word whose bits [1:0] are 11 appears unchanged on the output, and the illegal flag stays low.
- R2: An illegal compressed encoding raises the illegal flag and drives the output to 0x00000013. The all-zero halfword is illegal.
- R3: Quadrant 00, funct3 000 expands to `addi rd'+8, x2, uimm`. The immediate is zero-extended, scaled by 4 and covers bits 9:2. A zero immediate is illegal.
- R4: In quadrant 00, funct3 010/110 are word load/store and funct3 011/111 are doubleword load/store (64-bit mode). They use `rs1'+8` as the base and `rd'/rs2'+8` as data. Word offsets are zero-extended over bits 6:2 and doubleword offsets over bits 7:3.
- R5: In quadrant 01, funct3 000 expands to `addi rd, rd, simm6` and funct3 010 expands to `addi rd, x0, simm6`. Halfword 0x0001 gives 0x00000013 and is not illegal.
- R6: In quadrant 01, funct3 001 gives `addiw rd, rd, simm6` in 64-bit mode; a zero immediate is allowed and rd = x0 is illegal. In 32-bit mode the same slot gives `jal x1` with the 11:1 signed offset.
- R7: In quadrant 01, funct3 011 with rd = x2 gives `addi x2, x2, simm` with the immediate scaled by 16 (range -512..496); a zero immediate is illegal. Any other rd gives `lui rd, simm6` sign-extended from bit 17, illegal when rd = x0 or the immediate is zero.
- R8: In quadrant 01, funct3 100, bits 11:10 select the operation: 00 is logical right shift, 01 is arithmetic right shift, 10 is AND with a 6-bit signed immediate, 11 is register-register. In the register-register group with bit 12 = 0, bits 6:5 = 00/01/10/11 select sub/xor/or/and. With bit 12 = 1, 00/01 select subw/addw and 10/11 are illegal.
- R9: In quadrant 01, funct3 101 gives `jal x0` with an 11:1 signed offset. Funct3 110/111 give `beq`/`bne` of rs1'+8 against x0 with an 8:1 signed offset.
- R10: In quadrant 10, funct3 000 gives `slli rd, rd, shamt`. Funct3 010/011 give stack-relative word/doubleword loads off x2 (offsets over 7:2 and 8:3), illegal when rd = x0. Funct3 110/111 give stack-relative word/doubleword stores off x2.
- R11: In quadrant 10, with bits 15:12 = 1000: rs2 = 0 gives `jalr x0, rs1, 0` (illegal when rs1 = x0), and any other rs2 gives `add rd, x0, rs2`. With 1001: rd = rs2 = 0 gives ebreak (0x00100073), rs2 = 0 alone gives `jalr x1, rs1, 0`, and any other rs2 gives `add rd, rd, rs2`.
- R12: Quadrant 00 funct3 001/100/101 and quadrant 10 funct3 001/101 (floating-point or reserved) are illegal.
- R13: In 32-bit mode, the doubleword load/store slots, the word-arithmetic group and shift amounts with bit 12 set are illegal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Fetched instruction word; low halfword holds a compressed instruction when bits [1:0] are not 11 |
| expanded_o | output | 32 | Full-width equivalent instruction, or 0x00000013 when illegal |
| illegal_o | output | 1 | High when the compressed encoding is reserved or breaks a field rule |

## Verification
The bench builds two instances side by side: one with `WIDE_CORE = 1` and one with `WIDE_CORE = 0`. They receive the same stimulus, so the parameter-selected slots are exercised in both variants: add-immediate-word against jump-and-link, and doubleword and word-arithmetic forms against rejection. Random halfwords over all three quadrants reach every funct3 slot and every register-value split of the shared opcodes. Directed words pin the zero-immediate, x0-destination and reserved sub-encodings.

// File: rtl/cexp_pkg.sv
package cexp_pkg;

  localparam int INSN_W = 32;
  localparam int REG_W  = 5;

  localparam logic [6:0] OPC_LOAD   = 7'h03;
  localparam logic [6:0] OPC_IMM    = 7'h13;
  localparam logic [6:0] OPC_IMM32  = 7'h1B;
  localparam logic [6:0] OPC_STORE  = 7'h23;
  localparam logic [6:0] OPC_REG    = 7'h33;
  localparam logic [6:0] OPC_LUI    = 7'h37;
  localparam logic [6:0] OPC_REG32  = 7'h3B;
  localparam logic [6:0] OPC_BRANCH = 7'h63;
  localparam logic [6:0] OPC_JALR   = 7'h67;
  localparam logic [6:0] OPC_JAL    = 7'h6F;

  localparam logic [INSN_W-1:0] SAFE_WORD  = 32'h0000_0013;
  localparam logic [INSN_W-1:0] BREAK_WORD = 32'h0010_0073;

  localparam logic [REG_W-1:0] X0 = 5'd0;
  localparam logic [REG_W-1:0] X1 = 5'd1;
  localparam logic [REG_W-1:0] X2 = 5'd2;

  // 3-bit compact register field names x8..x15
  function automatic logic [REG_W-1:0] near_reg(input logic [2:0] f);
    return {2'b01, f};
  endfunction

  function automatic logic [INSN_W-1:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                              input logic [2:0] f3, input logic [4:0] rd,
                                              input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic logic [INSN_W-1:0] enc_s(input logic [11:0] imm, input logic [4:0] rs2,
                                              input logic [4:0] rs1, input logic [2:0] f3);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], OPC_STORE};
  endfunction

  function automatic logic [INSN_W-1:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2,
                                              input logic [4:0] rs1, input logic [2:0] f3,
                                              input logic [4:0] rd, input logic [6:0] op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction

  function automatic logic [INSN_W-1:0] enc_b(input logic [12:0] imm, input logic [4:0] rs1,
                                              input logic [2:0] f3);
    return {imm[12], imm[10:5], X0, rs1, f3, imm[4:1], imm[11], OPC_BRANCH};
  endfunction

  function automatic logic [INSN_W-1:0] enc_j(input logic [20:0] imm, input logic [4:0] rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, OPC_JAL};
  endfunction

  // jump offset of the compressed jump forms, bit 0 implied zero
  function automatic logic [20:0] jump_off(input logic [15:2] c);
    return {{9{c[12]}}, c[12], c[8], c[10:9], c[6], c[7], c[2], c[11], c[5:3], 1'b0};
  endfunction

endpackage

// File: rtl/cexp_quad0.sv
module cexp_quad0
  import cexp_pkg::*;
#(
  parameter bit WIDE_CORE = 1'b1
) (
  input  logic [15:2]       hw_i,
  output logic [INSN_W-1:0] word_o,
  output logic              bad_o
);

  logic [4:0] rd_n, rs1_n;
  logic [9:0] spn_imm;
  logic [6:0] w_off;
  logic [7:0] d_off;

  assign rd_n    = near_reg(hw_i[4:2]);
  assign rs1_n   = near_reg(hw_i[9:7]);
  assign spn_imm = {hw_i[10:7], hw_i[12:11], hw_i[5], hw_i[6], 2'b00};
  assign w_off   = {hw_i[5], hw_i[12:10], hw_i[6], 2'b00};
  assign d_off   = {hw_i[6:5], hw_i[12:10], 3'b000};

  always_comb begin
    word_o = SAFE_WORD;
    bad_o  = 1'b0;
    unique case (hw_i[15:13])
      3'b000: begin
        word_o = enc_i({2'b00, spn_imm}, X2, 3'b000, rd_n, OPC_IMM);
        bad_o  = (spn_imm == '0);
      end
      3'b010: word_o = enc_i({5'b0, w_off}, rs1_n, 3'b010, rd_n, OPC_LOAD);
      3'b011: begin
        word_o = enc_i({4'b0, d_off}, rs1_n, 3'b011, rd_n, OPC_LOAD);
        bad_o  = !WIDE_CORE;
      end
      3'b110: word_o = enc_s({5'b0, w_off}, rd_n, rs1_n, 3'b010);
      3'b111: begin
        word_o = enc_s({4'b0, d_off}, rd_n, rs1_n, 3'b011);
        bad_o  = !WIDE_CORE;
      end
      default: bad_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/cexp_quad1.sv
module cexp_quad1
  import cexp_pkg::*;
#(
  parameter bit WIDE_CORE = 1'b1
) (
  input  logic [15:2]       hw_i,
  output logic [INSN_W-1:0] word_o,
  output logic              bad_o
);

  logic [4:0]  rd_f, rs_n;
  logic [5:0]  imm6;
  logic [11:0] simm12;
  logic [9:0]  sp16;
  logic [12:0] br_off;
  logic [INSN_W-1:0] slot1_word, alu_word;
  logic        slot1_bad, alu_bad;

  assign rd_f   = hw_i[11:7];
  assign rs_n   = near_reg(hw_i[9:7]);
  assign imm6   = {hw_i[12], hw_i[6:2]};
  assign simm12 = {{6{hw_i[12]}}, imm6};
  assign sp16   = {hw_i[12], hw_i[4:3], hw_i[5], hw_i[2], hw_i[6], 4'b0000};
  assign br_off = {{4{hw_i[12]}}, hw_i[12], hw_i[6:5], hw_i[2], hw_i[11:10], hw_i[4:3], 1'b0};

  // funct3 001 holds a different instruction per core width
  generate
    if (WIDE_CORE) begin : g_addw_slot
      assign slot1_word = enc_i(simm12, rd_f, 3'b000, rd_f, OPC_IMM32);
      assign slot1_bad  = (rd_f == X0);
    end else begin : g_link_slot
      assign slot1_word = enc_j(jump_off(hw_i), X1);
      assign slot1_bad  = 1'b0;
    end
  endgenerate

  // funct3 100: shifts, and-immediate and register-register group
  always_comb begin
    alu_word = SAFE_WORD;
    alu_bad  = 1'b0;
    unique case (hw_i[11:10])
      2'b00: begin
        alu_word = enc_i({6'b000000, imm6}, rs_n, 3'b101, rs_n, OPC_IMM);
        alu_bad  = !WIDE_CORE && hw_i[12];
      end
      2'b01: begin
        alu_word = enc_i({6'b010000, imm6}, rs_n, 3'b101, rs_n, OPC_IMM);
        alu_bad  = !WIDE_CORE && hw_i[12];
      end
      2'b10: alu_word = enc_i(simm12, rs_n, 3'b111, rs_n, OPC_IMM);
      default: begin
        if (!hw_i[12]) begin
          unique case (hw_i[6:5])
            2'b00:   alu_word = enc_r(7'b0100000, near_reg(hw_i[4:2]), rs_n, 3'b000, rs_n, OPC_REG);
            2'b01:   alu_word = enc_r(7'b0000000, near_reg(hw_i[4:2]), rs_n, 3'b100, rs_n, OPC_REG);
            2'b10:   alu_word = enc_r(7'b0000000, near_reg(hw_i[4:2]), rs_n, 3'b110, rs_n, OPC_REG);
            default: alu_word = enc_r(7'b0000000, near_reg(hw_i[4:2]), rs_n, 3'b111, rs_n, OPC_REG);
          endcase
        end else begin
          unique case (hw_i[6:5])
            2'b00: begin
              alu_word = enc_r(7'b0100000, near_reg(hw_i[4:2]), rs_n, 3'b000, rs_n, OPC_REG32);
              alu_bad  = !WIDE_CORE;
            end
            2'b01: begin
              alu_word = enc_r(7'b0000000, near_reg(hw_i[4:2]), rs_n, 3'b000, rs_n, OPC_REG32);
              alu_bad  = !WIDE_CORE;
            end
            default: alu_bad = 1'b1;
          endcase
        end
      end
    endcase
  end

  always_comb begin
    word_o = SAFE_WORD;
    bad_o  = 1'b0;
    unique case (hw_i[15:13])
      3'b000: word_o = enc_i(simm12, rd_f, 3'b000, rd_f, OPC_IMM);
      3'b001: begin
        word_o = slot1_word;
        bad_o  = slot1_bad;
      end
      3'b010: word_o = enc_i(simm12, X0, 3'b000, rd_f, OPC_IMM);
      3'b011: begin
        if (rd_f == X2) begin
          word_o = enc_i({{2{hw_i[12]}}, sp16}, X2, 3'b000, X2, OPC_IMM);
          bad_o  = (sp16 == '0);
        end else begin
          word_o = {{14{hw_i[12]}}, imm6, rd_f, OPC_LUI};
          bad_o  = (rd_f == X0) || (imm6 == '0);
        end
      end
      3'b100: begin
        word_o = alu_word;
        bad_o  = alu_bad;
      end
      3'b101: word_o = enc_j(jump_off(hw_i), X0);
      3'b110: word_o = enc_b(br_off, rs_n, 3'b000);
      default: word_o = enc_b(br_off, rs_n, 3'b001);
    endcase
  end

endmodule

// File: rtl/cexp_quad2.sv
module cexp_quad2
  import cexp_pkg::*;
#(
  parameter bit WIDE_CORE = 1'b1
) (
  input  logic [15:2]       hw_i,
  output logic [INSN_W-1:0] word_o,
  output logic              bad_o
);

  logic [4:0] rd_f, rs2_f;
  logic [5:0] shamt;
  logic [7:0] lw_off, sw_off;
  logic [8:0] ld_off, sd_off;
  logic       rs2_zero, rd_zero;

  assign rd_f     = hw_i[11:7];
  assign rs2_f    = hw_i[6:2];
  assign shamt    = {hw_i[12], hw_i[6:2]};
  assign lw_off   = {hw_i[3:2], hw_i[12], hw_i[6:4], 2'b00};
  assign ld_off   = {hw_i[4:2], hw_i[12], hw_i[6:5], 3'b000};
  assign sw_off   = {hw_i[8:7], hw_i[12:9], 2'b00};
  assign sd_off   = {hw_i[9:7], hw_i[12:10], 3'b000};
  assign rs2_zero = (rs2_f == X0);
  assign rd_zero  = (rd_f == X0);

  always_comb begin
    word_o = SAFE_WORD;
    bad_o  = 1'b0;
    unique case (hw_i[15:13])
      3'b000: begin
        word_o = enc_i({6'b000000, shamt}, rd_f, 3'b001, rd_f, OPC_IMM);
        bad_o  = !WIDE_CORE && hw_i[12];
      end
      3'b010: begin
        word_o = enc_i({4'b0, lw_off}, X2, 3'b010, rd_f, OPC_LOAD);
        bad_o  = rd_zero;
      end
      3'b011: begin
        word_o = enc_i({3'b0, ld_off}, X2, 3'b011, rd_f, OPC_LOAD);
        bad_o  = rd_zero || !WIDE_CORE;
      end
      3'b100: begin
        if (!hw_i[12]) begin
          if (rs2_zero) begin
            word_o = enc_i(12'h000, rd_f, 3'b000, X0, OPC_JALR);
            bad_o  = rd_zero;
          end else begin
            word_o = enc_r(7'b0000000, rs2_f, X0, 3'b000, rd_f, OPC_REG);
          end
        end else begin
          if (rs2_zero && rd_zero)  word_o = BREAK_WORD;
          else if (rs2_zero)        word_o = enc_i(12'h000, rd_f, 3'b000, X1, OPC_JALR);
          else                      word_o = enc_r(7'b0000000, rs2_f, rd_f, 3'b000, rd_f, OPC_REG);
        end
      end
      3'b110: word_o = enc_s({4'b0, sw_off}, rs2_f, X2, 3'b010);
      3'b111: begin
        word_o = enc_s({3'b0, sd_off}, rs2_f, X2, 3'b011);
        bad_o  = !WIDE_CORE;
      end
      default: bad_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/cexp_top.sv
module cexp_top
  import cexp_pkg::*;
#(
  parameter bit WIDE_CORE = 1'b1
) (
  input  logic [INSN_W-1:0] instr_i,
  output logic [INSN_W-1:0] expanded_o,
  output logic              illegal_o
);

  logic                comp_sel;
  logic [INSN_W-1:0]   q0_word, q1_word, q2_word, pick_word;
  logic                q0_bad, q1_bad, q2_bad, pick_bad;

  assign comp_sel = (instr_i[1:0] != 2'b11);

  cexp_quad0 #(.WIDE_CORE(WIDE_CORE)) u_q0 (.hw_i(instr_i[15:2]), .word_o(q0_word), .bad_o(q0_bad));
  cexp_quad1 #(.WIDE_CORE(WIDE_CORE)) u_q1 (.hw_i(instr_i[15:2]), .word_o(q1_word), .bad_o(q1_bad));
  cexp_quad2 #(.WIDE_CORE(WIDE_CORE)) u_q2 (.hw_i(instr_i[15:2]), .word_o(q2_word), .bad_o(q2_bad));

  always_comb begin
    unique case (instr_i[1:0])
      2'b00: begin pick_word = q0_word;  pick_bad = q0_bad; end
      2'b01: begin pick_word = q1_word;  pick_bad = q1_bad; end
      2'b10: begin pick_word = q2_word;  pick_bad = q2_bad; end
      default: begin pick_word = instr_i; pick_bad = 1'b0; end
    endcase
  end

  assign illegal_o  = comp_sel && pick_bad;
  assign expanded_o = illegal_o ? SAFE_WORD : pick_word;

endmodule

// File: rtl/cexp_checker.sv
module cexp_checker (
  input logic [31:0] instr_i,
  input logic [31:0] expanded_o,
  input logic        illegal_o,
  input logic        comp_sel
);

  logic [2:0] f3;
  assign f3 = instr_i[15:13];

  always_comb begin
    assert_passthrough_R1: assert (comp_sel || (expanded_o == instr_i && !illegal_o))
      else $error("full-width word altered");
    assert_safe_word_R2: assert (!illegal_o || (comp_sel && expanded_o == 32'h0000_0013))
      else $error("illegal output not the safe word");
    assert_near_base_R4: assert (!(comp_sel && instr_i[1:0] == 2'b00 && f3 != 3'b000 && !illegal_o)
                                 || expanded_o[19:18] == 2'b01)
      else $error("quadrant 0 base register outside x8..x15");
    assert_branch_zero_R9: assert (!(comp_sel && instr_i[1:0] == 2'b01 && f3[2:1] == 2'b11)
                                   || (expanded_o[6:0] == 7'h63 && expanded_o[24:20] == 5'd0))
      else $error("compact branch not compared with x0");
    assert_stack_base_R10: assert (!(comp_sel && instr_i[1:0] == 2'b10 && f3[1] && !illegal_o)
                                   || expanded_o[19:15] == 5'd2)
      else $error("stack access not based on x2");
  end

endmodule

bind cexp_top cexp_checker chk_i (
  .instr_i(instr_i),
  .expanded_o(expanded_o),
  .illegal_o(illegal_o),
  .comp_sel(comp_sel)
);

// File: tb/cexp_top_tb_top.sv
module cexp_top_tb_top;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] instr;
  logic [31:0] out64, out32;
  logic        bad64, bad32;
  int          n_checks = 0;
  int          n_fail   = 0;
  bit          finished = 0;

  cexp_top #(.WIDE_CORE(1'b1)) dut_i   (.instr_i(instr), .expanded_o(out64), .illegal_o(bad64));
  cexp_top #(.WIDE_CORE(1'b0)) dut32_i (.instr_i(instr), .expanded_o(out32), .illegal_o(bad32));

  function automatic int fb(int c, int n);
    return (c >> n) & 1;
  endfunction

  function automatic int fld(int c, int hi, int lo);
    return (c >> lo) & ((1 << (hi - lo + 1)) - 1);
  endfunction

  function automatic int mk_i(int imm, int rs1, int f3, int rd, int op);
    return ((imm & 'hFFF) << 20) | (rs1 << 15) | (f3 << 12) | (rd << 7) | op;
  endfunction

  function automatic int mk_s(int imm, int rs2, int rs1, int f3);
    return (((imm >> 5) & 'h7F) << 25) | (rs2 << 20) | (rs1 << 15) | (f3 << 12) | ((imm & 'h1F) << 7) | 'h23;
  endfunction

  function automatic int mk_r(int f7, int rs2, int rs1, int f3, int rd, int op);
    return (f7 << 25) | (rs2 << 20) | (rs1 << 15) | (f3 << 12) | (rd << 7) | op;
  endfunction

  function automatic int mk_b(int imm, int rs1, int f3);
    return (((imm >> 12) & 1) << 31) | (((imm >> 5) & 'h3F) << 25) | (rs1 << 15) | (f3 << 12)
         | (((imm >> 1) & 'hF) << 8) | (((imm >> 11) & 1) << 7) | 'h63;
  endfunction

  function automatic int mk_j(int imm, int rd);
    return (((imm >> 20) & 1) << 31) | (((imm >> 1) & 'h3FF) << 21) | (((imm >> 11) & 1) << 20)
         | (((imm >> 12) & 'hFF) << 12) | (rd << 7) | 'h6F;
  endfunction

  function automatic int sx(int v, int bits);
    return (v >= (1 << (bits - 1))) ? v - (1 << bits) : v;
  endfunction

  function automatic int joff(int c);
    return sx(fb(c,12)*2048 + fb(c,8)*1024 + fld(c,10,9)*256 + fb(c,6)*128 + fb(c,7)*64
              + fb(c,2)*32 + fb(c,11)*16 + fld(c,5,3)*2, 12);
  endfunction

  // returns {illegal, word}
  function automatic logic [32:0] model(int w, bit wide);
    int c = w & 'hFFFF;
    int q = c & 3;
    int f = fld(c, 15, 13);
    int rd = fld(c, 11, 7);
    int rs2 = fld(c, 6, 2);
    int np = 8 + fld(c, 9, 7);
    int nq = 8 + fld(c, 4, 2);
    int i6 = sx(fb(c,12)*32 + rs2, 6);
    int u6 = fb(c,12)*32 + rs2;
    int res = 'h13;
    bit bad = 0;
    if (q == 3) return {1'b0, w[31:0]};
    if (q == 0) begin
      int woff = fb(c,5)*64 + fld(c,12,10)*8 + fb(c,6)*4;
      int doff = fld(c,6,5)*64 + fld(c,12,10)*8;
      case (f)
        0: begin
          int im = fld(c,10,7)*64 + fld(c,12,11)*16 + fb(c,5)*8 + fb(c,6)*4;
          res = mk_i(im, 2, 0, nq, 'h13); bad = (im == 0);
        end
        2: res = mk_i(woff, np, 2, nq, 'h03);
        3: begin res = mk_i(doff, np, 3, nq, 'h03); bad = !wide; end
        6: res = mk_s(woff, nq, np, 2);
        7: begin res = mk_s(doff, nq, np, 3); bad = !wide; end
        default: bad = 1;
      endcase
    end else if (q == 1) begin
      case (f)
        0: res = mk_i(i6, rd, 0, rd, 'h13);
        1: if (wide) begin res = mk_i(i6, rd, 0, rd, 'h1B); bad = (rd == 0); end
           else res = mk_j(joff(c), 1);
        2: res = mk_i(i6, 0, 0, rd, 'h13);
        3: if (rd == 2) begin
             int s = sx(fb(c,12)*512 + fld(c,4,3)*128 + fb(c,5)*64 + fb(c,2)*32 + fb(c,6)*16, 10);
             res = mk_i(s, 2, 0, 2, 'h13); bad = (s == 0);
           end else begin
             res = ((i6 & 'hFFFFF) << 12) | (rd << 7) | 'h37; bad = (rd == 0) || (u6 == 0);
           end
        4: case (fld(c,11,10))
             0: begin res = mk_i(u6, np, 5, np, 'h13); bad = !wide && fb(c,12); end
             1: begin res = mk_i(u6 + 'h400, np, 5, np, 'h13); bad = !wide && fb(c,12); end
             2: res = mk_i(i6, np, 7, np, 'h13);
             default: begin
               int op = fld(c,6,5);
               if (fb(c,12) == 0) begin
                 int f3s [4] = '{0, 4, 6, 7};
                 res = mk_r(op == 0 ? 'h20 : 0, nq, np, f3s[op], np, 'h33);
               end else if (op < 2) begin
                 res = mk_r(op == 0 ? 'h20 : 0, nq, np, 0, np, 'h3B); bad = !wide;
               end else bad = 1;
             end
           endcase
        5: res = mk_j(joff(c), 0);
        default: begin
          int bo = sx(fb(c,12)*256 + fld(c,6,5)*64 + fb(c,2)*32 + fld(c,11,10)*8 + fld(c,4,3)*2, 9);
          res = mk_b(bo, np, f - 6);
        end
      endcase
    end else begin
      case (f)
        0: begin res = mk_i(u6, rd, 1, rd, 'h13); bad = !wide && fb(c,12); end
        2: begin res = mk_i(fld(c,3,2)*64 + fb(c,12)*32 + fld(c,6,4)*4, 2, 2, rd, 'h03); bad = (rd == 0); end
        3: begin res = mk_i(fld(c,4,2)*64 + fb(c,12)*32 + fld(c,6,5)*8, 2, 3, rd, 'h03); bad = (rd == 0) || !wide; end
        4: if (fb(c,12) == 0) begin
             if (rs2 == 0) begin res = mk_i(0, rd, 0, 0, 'h67); bad = (rd == 0); end
             else res = mk_r(0, rs2, 0, 0, rd, 'h33);
           end else begin
             if (rs2 == 0 && rd == 0) res = 'h00100073;
             else if (rs2 == 0) res = mk_i(0, rd, 0, 1, 'h67);
             else res = mk_r(0, rs2, rd, 0, rd, 'h33);
           end
        6: res = mk_s(fld(c,8,7)*64 + fld(c,12,9)*4, rs2, 2, 2);
        7: begin res = mk_s(fld(c,9,7)*64 + fld(c,12,10)*8, rs2, 2, 3); bad = !wide; end
        default: bad = 1;
      endcase
    end
    if (bad) res = 'h13;
    return {bad, res[31:0]};
  endfunction

  function automatic string req_of(int w);
    int q = w & 3;
    int f = (w >> 13) & 7;
    if (q == 3) return "R1";
    if (q == 0) return (f == 0) ? "R3" : (f == 2 || f == 3 || f == 6 || f == 7) ? "R4" : "R12";
    if (q == 1) begin
      case (f)
        0, 2: return "R5";
        1: return "R6";
        3: return "R7";
        4: return "R8";
        default: return "R9";
      endcase
    end
    return (f == 4) ? "R11" : (f == 1 || f == 5) ? "R12" : "R10";
  endfunction

  task automatic check(string req, string what, logic [32:0] got, logic [32:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: instr=%08h got bad=%0d word=%08h expected bad=%0d word=%08h",
               req, what, instr, got[32], got[31:0], exp[32], exp[31:0]);
    end
  endtask

  task automatic apply(logic [31:0] w);
    @(posedge clk);
    instr = w;
    @(negedge clk);
  endtask

  // directed vector against a literal expectation on the 64-bit instance
  task automatic lit64(string req, logic [31:0] w, bit ebad, logic [31:0] eword);
    apply(w);
    check(req, "literal", {bad64, out64}, {ebad, eword});
  endtask

  task automatic both(string req, logic [31:0] w);
    apply(w);
    check(req, "wide", {bad64, out64}, model(w, 1'b1));
    check(req, "narrow", {bad32, out32}, model(w, 1'b0));
  endtask

  initial begin
    instr = 32'h0000_0013;
    repeat (2) @(posedge clk);
    // R1 passthrough on both widths
    both("R1", 32'h00A0_0093);
    both("R1", 32'hFFFF_FFFF);
    // R2 all-zero halfword is illegal and gives the safe word
    lit64("R2", 32'h0000_0000, 1'b1, 32'h0000_0013);
    // R3 stack pointer based add, and zero immediate
    lit64("R3", 32'h0000_0040, 1'b0, 32'h0041_0413);
    lit64("R3", 32'h0000_001C, 1'b1, 32'h0000_0013);
    // R4 word load off x9 into x8
    lit64("R4", 32'h0000_4080, 1'b0, 32'h0004_A403);
    both("R4", 32'h0000_FFFC);
    // R5 nop and load-immediate -1 into x10
    lit64("R5", 32'h0000_0001, 1'b0, 32'h0000_0013);
    lit64("R5", 32'h0000_557D, 1'b0, 32'hFFF0_0513);
    // R6 add-immediate-word with zero immediate, rd x0, narrow-core link jump
    lit64("R6", 32'h0000_2081, 1'b0, 32'h0000_809B);
    lit64("R6", 32'h0000_2001, 1'b1, 32'h0000_0013);
    apply(32'h0000_2001);
    check("R6", "narrow link", {bad32, out32}, {1'b0, 32'h0000_00EF});
    // R7 stack adjust -512, zero stack adjust, zero lui immediate
    lit64("R7", 32'h0000_7101, 1'b0, 32'hE001_0113);
    lit64("R7", 32'h0000_6101, 1'b1, 32'h0000_0013);
    lit64("R7", 32'h0000_6081, 1'b1, 32'h0000_0013);
    both("R7", 32'h0000_70FD);
    // R8 subw, reserved word-group slot
    both("R8", 32'h0000_9C01);
    lit64("R8", 32'h0000_9C41, 1'b1, 32'h0000_0013);
    both("R8", 32'h0000_8C7D);
    // R9 jump and branch with zero offsets, plus extreme offsets
    lit64("R9", 32'h0000_A001, 1'b0, 32'h0000_006F);
    lit64("R9", 32'h0000_C001, 1'b0, 32'h0004_0063);
    both("R9", 32'h0000_BFFD);
    both("R9", 32'h0000_FFFD);
    // R10 stack load into x0 is illegal, doubleword stack load, stores
    lit64("R10", 32'h0000_4002, 1'b1, 32'h0000_0013);
    both("R10", 32'h0000_6082);
    both("R10", 32'h0000_FFFE);
    both("R10", 32'h0000_DFFE);
    // R11 ebreak, return, jump through x0, indirect call, move, add
    lit64("R11", 32'h0000_9002, 1'b0, 32'h0010_0073);
    lit64("R11", 32'h0000_8082, 1'b0, 32'h0000_8067);
    lit64("R11", 32'h0000_8002, 1'b1, 32'h0000_0013);
    lit64("R11", 32'h0000_9082, 1'b0, 32'h0000_80E7);
    both("R11", 32'h0000_852E);
    both("R11", 32'h0000_952E);
    // R12 floating-point and reserved slots
    lit64("R12", 32'h0000_2000, 1'b1, 32'h0000_0013);
    lit64("R12", 32'h0000_8000, 1'b1, 32'h0000_0013);
    lit64("R12", 32'h0000_A002, 1'b1, 32'h0000_0013);
    // R13 narrow core rejects doubleword, word arithmetic and wide shifts
    apply(32'h0000_6000);
    check("R13", "narrow dword load", {bad32, out32}, {1'b1, 32'h0000_0013});
    apply(32'h0000_9C01);
    check("R13", "narrow subw", {bad32, out32}, {1'b1, 32'h0000_0013});
    apply(32'h0000_1006);
    check("R13", "narrow shift", {bad32, out32}, {1'b1, 32'h0000_0013});

    // random halfwords over all quadrants, both widths
    void'($urandom(32'd20240611));
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] w = $urandom;
      if (i % 16 != 0 && w[1:0] == 2'b11) w[1:0] = 2'(i % 3);
      apply(w);
      check(req_of(w), "random wide", {bad64, out64}, model(w, 1'b1));
      check(req_of(w), "random narrow", {bad32, out32}, model(w, 1'b0));
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule